// File: doc/BRIEF.md
# Codec Control Word Serial Writer

This block sends single register writes to one of two audio converter chips over a write-only three-wire control port: a serial clock, a serial data line and one active-low select per chip. A write request names a chip (one bit), a 5-bit register address and an 8-bit value. The block packs these into a 16-bit control word and shifts it out most significant bit first. The chosen chip's select is held low for the whole word.

Every pin change is followed by a programmable settling delay, counted in system clocks. The port idles with every line high. It also spends one settling step fully high before the select drops, and one more after all lines return high. A busy flag covers the whole transaction, and a one-cycle done pulse follows it. The host may only issue a request while the block is idle.

Top module: `codec_ctl_writer`

## Requirements
- R1: The control word is, from bit 15 down to bit 0: the device prefix binary 10 in bits 15:14, a constant 1 in bit 13, the register address in bits 12:8 and the data byte in bits 7:0.
- R2: Each transaction clocks out exactly 16 bits, most significant first, and has no read phase.
- R3: For every bit, the clock falls first, then the data line takes the bit value, then the clock rises. The data line does not change on either clock edge, so the receiver can sample on the rising edge.
- R4: After a request is accepted, clock, data and both selects stay high for one settling step. Only then does the addressed select go low.
- R5: When the last bit's clock-high step ends, the clock, the data line and the active select all go high on the same cycle.
- R6: Chip index 0 drives cs_n[0] low and index 1 drives cs_n[1] low. The other select stays high, and at most one select is ever low.
- R7: Each step lasts exactly STEP_CYCLES system clocks, so no pin changes again sooner than STEP_CYCLES clocks after the previous change.
- R8: busy is high from the cycle after the request is accepted until the final all-high step has elapsed. done is high for exactly one cycle, namely the first cycle in which busy reads low again.
- R9: A start request raised while busy has no effect: no second word appears on the port and the word in progress is unchanged.
- R10: A synchronous active-high reset drives sclk, sdata and both selects high and clears busy and done, even in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Write request, sampled only while idle |
| chip_idx | input | 1 | Target chip: 0 selects cs_n[0], 1 selects cs_n[1] |
| reg_addr | input | 5 | Register address placed in bits 12:8 |
| wr_data | input | 8 | Data byte placed in bits 7:0 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, idles high |
| cs_n | output | 2 | Active-low chip selects, one per chip |

## Verification
The scoreboard rebuilds every word from the rising clock edges and compares it against the request. All-zero and all-one payloads are included, so a wrong or missing prefix or write bit, or a shift in the wrong direction, shows up as a bad bit. A start pulse in the middle of a word must not create a second word, and a design that re-arms while busy fails this because the scoreboard reports a word it did not expect. The bench counts the cycles of the all-high lead-in and tail, so a dropped or shortened lead-in or tail step is flagged. It also checks each select, so swapped selects are caught. A reset raised mid-word must leave every line high at once, and a design whose lines linger low after reset fails this.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD,
      PH_SELECT,
      PH_CLK_LO,
      PH_DATA,
      PH_CLK_HI,
      PH_TAIL
   } wr_phase_t;
endpackage

// File: rtl/ccw_step_timer.sv
module ccw_step_timer #(
   parameter int STEP_CYCLES = 25
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic expired
);
   generate
      if (STEP_CYCLES <= 1) begin : g_single
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst, restart};
         assign expired = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(STEP_CYCLES);
         localparam logic [CW-1:0] RELOAD = CW'(STEP_CYCLES - 1);
         logic [CW-1:0] remain;
         always_ff @(posedge clk) begin
            if (rst)
               remain <= '0;
            else if (restart)
               remain <= RELOAD;
            else if (remain != '0)
               remain <= remain - 1'b1;
         end
         assign expired = (remain == '0);
      end
   endgenerate
endmodule

// File: rtl/ccw_frame_shift.sv
module ccw_frame_shift #(
   parameter int          ADDR_W = 5,
   parameter int          DATA_W = 8,
   parameter logic [1:0]  DEV_ID = 2'b10,
   localparam int         FRAME_W = 3 + ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              advance,
   output logic              head
);
   logic [FRAME_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (rst)
         word_q <= '0;
      else if (load)
         word_q <= {DEV_ID, 1'b1, addr, data};
      else if (advance)
         word_q <= {word_q[FRAME_W-2:0], 1'b0};
   end

   assign head = word_q[FRAME_W-1];
endmodule

// File: rtl/codec_ctl_writer.sv
module codec_ctl_writer #(
   parameter int         STEP_CYCLES = 25,
   parameter int         ADDR_W      = 5,
   parameter int         DATA_W      = 8,
   parameter logic [1:0] DEV_ID      = 2'b10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              chip_idx,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done,
   output logic              sclk,
   output logic              sdata,
   output logic [1:0]        cs_n
);
   import codec_ctl_pkg::*;

   localparam int FRAME_W = 3 + ADDR_W + DATA_W;
   localparam int BCW     = $clog2(FRAME_W);
   localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_W - 1);

   generate
      if (STEP_CYCLES < 1) begin : g_bad_step
         $error("STEP_CYCLES must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be at least 1");
      end
   endgenerate

   wr_phase_t      phase_q;
   logic           sclk_q, sdata_q, done_q, sel_q;
   logic [BCW-1:0] bit_q;
   logic           step_end, restart, accept, head, advance, last_end, drop_sel;

   assign accept   = (phase_q == PH_IDLE) && start;
   assign restart  = accept || ((phase_q != PH_IDLE) && step_end);
   assign advance  = (phase_q == PH_CLK_LO) && step_end;
   assign last_end = (phase_q == PH_CLK_HI) && step_end && (bit_q == LAST_BIT);
   assign drop_sel = (phase_q == PH_LEAD) && step_end;

   ccw_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .expired (step_end)
   );

   ccw_frame_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_frame (
      .clk     (clk),
      .rst     (rst),
      .load    (accept),
      .addr    (reg_addr),
      .data    (wr_data),
      .advance (advance),
      .head    (head)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         sclk_q  <= 1'b1;
         sdata_q <= 1'b1;
         sel_q   <= 1'b0;
         bit_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE:
               if (start) begin
                  phase_q <= PH_LEAD;
                  sel_q   <= chip_idx;
               end
            PH_LEAD:
               if (step_end) phase_q <= PH_SELECT;
            PH_SELECT:
               if (step_end) begin
                  phase_q <= PH_CLK_LO;
                  sclk_q  <= 1'b0;
                  bit_q   <= '0;
               end
            PH_CLK_LO:
               if (step_end) begin
                  phase_q <= PH_DATA;
                  sdata_q <= head;
               end
            PH_DATA:
               if (step_end) begin
                  phase_q <= PH_CLK_HI;
                  sclk_q  <= 1'b1;
               end
            PH_CLK_HI:
               if (step_end) begin
                  if (bit_q == LAST_BIT) begin
                     phase_q <= PH_TAIL;
                     sdata_q <= 1'b1;
                  end else begin
                     phase_q <= PH_CLK_LO;
                     sclk_q  <= 1'b0;
                     bit_q   <= bit_q + 1'b1;
                  end
               end
            PH_TAIL:
               if (step_end) begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   generate
      for (genvar k = 0; k < 2; k++) begin : g_sel
         localparam logic MY_IDX = (k != 0);
         logic cs_q;
         always_ff @(posedge clk) begin
            if (rst)
               cs_q <= 1'b1;
            else if (drop_sel && (sel_q == MY_IDX))
               cs_q <= 1'b0;
            else if (last_end)
               cs_q <= 1'b1;
         end
         assign cs_n[k] = cs_q;
      end
   endgenerate

   assign busy  = (phase_q != PH_IDLE);
   assign done  = done_q;
   assign sclk  = sclk_q;
   assign sdata = sdata_q;
endmodule

// File: rtl/ccw_checker.sv
module ccw_checker #(
   parameter int STEP_CYCLES = 25,
   parameter int FRAME_W     = 16
) (
   input logic       clk,
   input logic       rst,
   input logic       busy,
   input logic       done,
   input logic       sclk,
   input logic       sdata,
   input logic [1:0] cs_n
);
   logic [3:0] pins, pins_d;
   logic       sclk_d, seen_change;
   int         rise_cnt, gap;

   assign pins = {sclk, sdata, cs_n};

   always_ff @(posedge clk) begin
      if (rst) begin
         pins_d      <= 4'hF;
         sclk_d      <= 1'b1;
         rise_cnt    <= 0;
         gap         <= 0;
         seen_change <= 1'b0;
      end else begin
         pins_d <= pins;
         sclk_d <= sclk;
         if (!busy) rise_cnt <= 0;
         else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1;
         if (pins != pins_d) gap <= 1;
         else if (gap < 1000000) gap <= gap + 1;
         if (!busy) seen_change <= 1'b0;
         else if (pins != pins_d) seen_change <= 1'b1;
      end
   end

   // R2: exactly one rising clock edge per word bit
   a_r2_bit_count: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> rise_cnt == FRAME_W);

   // R3: data never moves on a clock edge
   a_r3_stable_on_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(sclk) |-> $stable(sdata));
   a_r3_stable_on_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(sclk) |-> $stable(sdata));

   // R4: lines high before a select drops
   a_r4_high_before_select: assert property (@(posedge clk) disable iff (rst)
      ($fell(cs_n[0]) || $fell(cs_n[1])) |-> (sclk && sdata && $past(sclk) && $past(sdata)));

   // R5: release together
   a_r5_release_together: assert property (@(posedge clk) disable iff (rst)
      ($rose(cs_n[0]) || $rose(cs_n[1])) |-> (sclk && sdata));

   // R6: at most one select low
   a_r6_one_select: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~cs_n));

   // R7: minimum settling time between pin changes
   a_r7_step_gap: assert property (@(posedge clk) disable iff (rst)
      (busy && (pins != pins_d) && seen_change) |-> gap >= STEP_CYCLES);

   // R8: done is a single cycle right after busy
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && $past(busy)));

   // R10: reset leaves the port idle
   a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (sclk && sdata && cs_n == 2'b11 && !busy && !done));
endmodule

bind codec_ctl_writer ccw_checker #(.STEP_CYCLES(STEP_CYCLES), .FRAME_W(FRAME_W)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .busy  (busy),
   .done  (done),
   .sclk  (sclk),
   .sdata (sdata),
   .cs_n  (cs_n)
);

// File: tb/codec_ctl_writer_tb_top.sv
module codec_ctl_writer_tb_top;
   localparam int STEP = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       chip_idx = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [7:0] wr_data = '0;
   logic       busy, done, sclk, sdata;
   logic [1:0] cs_n;

   int n_chk = 0;
   int n_bad = 0;
   int n_words = 0;
   bit finished = 0;

   logic [16:0] exp_q[$];

   always #2 clk = ~clk;

   codec_ctl_writer #(.STEP_CYCLES(STEP)) dut_i (
      .clk(clk), .rst(rst), .start(start), .chip_idx(chip_idx),
      .reg_addr(reg_addr), .wr_data(wr_data), .busy(busy), .done(done),
      .sclk(sclk), .sdata(sdata), .cs_n(cs_n)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // monitor
   logic [1:0]  prev_cs = 2'b11;
   logic        prev_sclk = 1'b1, prev_sdata = 1'b1, prev_done = 1'b0;
   bit          capturing = 0, in_tail = 0;
   int          nbits = 0, lead_cnt = 0, tail_cnt = 0;
   logic [15:0] shreg = '0;
   logic        chip_seen = 1'b0;

   always @(negedge clk) begin
      if (rst) begin
         capturing = 0; in_tail = 0; lead_cnt = 0; tail_cnt = 0;
         exp_q.delete();
      end else begin
         if (done && prev_done)
            check(0, "R8", "done longer than one cycle", 2, 1);
         if (prev_cs == 2'b11 && cs_n != 2'b11) begin
            check(cs_n == 2'b10 || cs_n == 2'b01, "R6", "select pattern", cs_n, 2'b10);
            check(sclk && sdata, "R4", "clk/data at select drop", {sclk, sdata}, 2'b11);
            check(lead_cnt == STEP, "R4", "lead-in cycles", lead_cnt, STEP);
            chip_seen = (cs_n == 2'b01);
            capturing = 1; nbits = 0; shreg = '0;
         end
         if (busy && cs_n == 2'b11 && !capturing && !in_tail) lead_cnt++;
         if (!busy) lead_cnt = 0;
         if (capturing && !prev_sclk && sclk) begin
            if (sdata != prev_sdata)
               check(0, "R3", "data moved with rising clock", sdata, prev_sdata);
            shreg = {shreg[14:0], sdata};
            nbits++;
         end
         if (capturing && prev_cs != 2'b11 && cs_n == 2'b11) begin
            capturing = 0;
            n_words++;
            check(sclk && sdata, "R5", "clk/data at release", {sclk, sdata}, 2'b11);
            check(nbits == 16, "R2", "bits per word", nbits, 16);
            if (exp_q.size() == 0) begin
               check(0, "R9", "unexpected word", {chip_seen, shreg}, 0);
            end else begin
               logic [16:0] e;
               e = exp_q.pop_front();
               check(shreg == e[15:0], "R1", "word contents", shreg, e[15:0]);
               check(chip_seen == e[16], "R6", "chip selected", chip_seen, e[16]);
            end
            in_tail = 1; tail_cnt = 0;
         end
         if (in_tail && busy) tail_cnt++;
         if (in_tail && !busy) begin
            check(tail_cnt == STEP, "R7", "tail cycles", tail_cnt, STEP);
            check(done, "R8", "done at busy fall", done, 1);
            in_tail = 0;
         end
      end
      prev_cs = cs_n; prev_sclk = sclk; prev_sdata = sdata; prev_done = done;
   end

   task automatic send(input logic chip, input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      while (busy) @(negedge clk);
      chip_idx = chip; reg_addr = a; wr_data = d; start = 1'b1;
      exp_q.push_back({chip, 2'b10, 1'b1, a, d});
      @(negedge clk);
      start = 1'b0;
      check(busy, "R8", "busy after accept", busy, 1);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(sclk && sdata && cs_n == 2'b11 && !busy && !done, "R10", "reset state",
            {busy, done, sclk, sdata, cs_n}, 6'b001111);
      rst = 1'b0;

      send(0, 5'h00, 8'h00); wait_idle();
      send(1, 5'h1F, 8'hFF); wait_idle();
      send(0, 5'h15, 8'hA5); wait_idle();
      send(1, 5'h0A, 8'h3C); wait_idle();

      // R9: request while busy is ignored
      send(0, 5'h02, 8'h81);
      repeat (20) @(negedge clk);
      chip_idx = 1'b1; reg_addr = 5'h1E; wr_data = 8'h7E; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      repeat (10) @(negedge clk);
      check(!busy && cs_n == 2'b11, "R9", "idle after ignored request", {busy, cs_n}, 3'b011);

      // back-to-back: request in the done cycle
      send(1, 5'h11, 8'h5A);
      @(negedge clk);
      while (!done) @(negedge clk);
      chip_idx = 1'b0; reg_addr = 5'h03; wr_data = 8'hC3; start = 1'b1;
      exp_q.push_back({1'b0, 2'b10, 1'b1, 5'h03, 8'hC3});
      @(negedge clk);
      start = 1'b0;
      check(busy, "R8", "accept in done cycle", busy, 1);
      wait_idle();

      // R10: reset mid-word
      send(1, 5'h07, 8'h00);
      repeat (40) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(sclk && sdata && cs_n == 2'b11 && !busy && !done, "R10", "mid-word reset",
            {busy, done, sclk, sdata, cs_n}, 6'b001111);
      @(negedge clk);
      rst = 1'b0;
      send(0, 5'h19, 8'h96); wait_idle();

      check(exp_q.size() == 0, "R2", "words outstanding", exp_q.size(), 0);
      check(n_words == 8, "R9", "words observed", n_words, 8);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule